// File: doc/BRIEF.md
# Byte-Addressed GPIO Port Bank

This block is a memory-mapped bank of general-purpose pins: eight ports of 32 pins, 256 pins in all, numbered linearly. Every pin owns a byte location of its own in the low address range. Software can therefore set, clear or sample one pin with a single byte access and never needs a read-modify-write cycle. A second address range holds one 32-bit direction word per port. A 1 in that word makes the matching pin an output. A 0 makes it an input.

The block sits on a simple word-wide register bus with four byte-lane strobes. A data byte written with any nonzero value stores a 1 in the pin's output latch, and a zero byte stores a 0. The latch keeps its value while the pin is an input, and the pin drives that value once it becomes an output. A read of a pin's byte gives the driven level for an output pin. For an input pin it gives the pad level after a two-flop synchronizer. Read data is registered, so it appears one cycle after the address is presented.

Top module: `gpio_bank`

## Requirements
- R1: While `rst_n` is low and after it rises, all direction bits are 0 and all output latches are 0, so `pin_oe` and `pin_out` are all zero. `bus_rdata` is 0 during reset.
- R2: A write to byte address A below 256 affects only those lanes l whose `bus_be[l]` is 1. Such a lane updates the latch of pin (A with bits 1:0 cleared) + l, where lane l is `bus_wdata[8l+7:8l]`. A nonzero lane byte stores 1 and a zero lane byte stores 0. Lanes whose strobe is 0 leave their pin untouched.
- R3: The direction word of port n is at byte address 0x2000 + 4n, and its bit b controls pin 32n + b. A write updates only the bytes whose strobe is set, and a read returns the stored word.
- R4: `pin_oe[p]` equals the direction bit of pin p. `pin_out[p]` is the latch of pin p when that bit is 1, and 0 otherwise.
- R5: Each byte returned from the data range is exactly 0x00 or 0x01. For an output pin, bit 0 of the byte is the value held in its latch.
- R6: For an input pin, the data byte returns `pin_in` through two synchronizing flops. Suppose `pin_in` changes just after clock edge k while the address is held. Reads registered at edges k+1 and k+2 still show the old level, and the read registered at edge k+3 shows the new one.
- R7: A data write to an input pin updates its latch without changing `pin_out`. When the pin later becomes an output, it drives the stored value.
- R8: Addresses outside both ranges (for example 0x100 to 0x1FFF, or 0x2020 and above) read as 0. Writes to them change no latch and no direction bit.
- R9: `bus_rdata` is loaded on the clock edge that ends the access cycle. It reflects the state before any write presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Byte address of the access; bits 1:0 are ignored |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_be | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data, lane l in bits 8l+7:8l |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 256 | Pad input levels, one per pin |
| pin_out | output | 256 | Driven pin levels, zero for input pins |
| pin_oe | output | 256 | Output enables, one per pin |

## Verification
Three activities can coincide in one cycle: a write and the registered read of the same location, and an input edge arriving while that pin's byte is being read. The bench writes a pin's byte and a direction word while reading the same address in that cycle. It expects the pre-write contents, and then the new contents on the following access. It also toggles one input exactly as the read address settles and expects the old level for two reads before the new one appears. This confirms the read path samples the second synchronizer stage and not the raw pad.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int LANE_W = $clog2(LANES);

  // Address lies inside the per-pin byte range.
  function automatic logic in_data_span(input logic [31:0] a, input int unsigned npins);
    return a < npins;
  endfunction

  // Address lies inside the direction-word range.
  function automatic logic in_dir_span(input logic [31:0] a, input int unsigned base,
                                       input int unsigned nports);
    return (a >= base) && (a < base + nports * LANES);
  endfunction

  // Port number addressed inside the direction range.
  function automatic logic [31:0] dir_port_of(input logic [31:0] a, input int unsigned base);
    return (a - base) >> LANE_W;
  endfunction

  // Collapse a written byte to the pin level it stores.
  function automatic logic byte_to_level(input logic [7:0] b);
    return |b;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 256,
  parameter int WIDX_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [WIDX_W-1:0]   word_idx,
  input  logic [LANES-1:0]    be,
  input  logic [BUS_W-1:0]    wdata,
  output logic [NUM_PINS-1:0] latch_q
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WORD = p / LANES;
    localparam int LANE = p % LANES;
    logic hit;
    assign hit = wr_hit && (word_idx == WIDX_W'(WORD)) && be[LANE];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   latch_q[p] <= 1'b0;
      else if (hit) latch_q[p] <= byte_to_level(wdata[LANE*8 +: 8]);
    end
  end

endmodule

// File: rtl/gpio_dir_bank.sv
module gpio_dir_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int PINS_PER_PORT = 32,
  parameter int PIDX_W        = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_hit,
  input  logic [PIDX_W-1:0]                       port_idx,
  input  logic [LANES-1:0]                        be,
  input  logic [BUS_W-1:0]                        wdata,
  output logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dir_words
);

  localparam int BYTES = PINS_PER_PORT / 8;

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    logic sel;
    assign sel = wr_hit && (port_idx == PIDX_W'(n));
    for (genvar l = 0; l < BYTES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              dir_words[n][l*8 +: 8] <= '0;
        else if (sel && be[l])   dir_words[n][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int PINS_PER_PORT = 32,
  parameter int WIDX_W        = 6,
  parameter int PIDX_W        = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    data_hit,
  input  logic                                    dir_hit,
  input  logic [WIDX_W-1:0]                       word_idx,
  input  logic [PIDX_W-1:0]                       port_idx,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]      level,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dir_words,
  output logic [BUS_W-1:0]                        rdata
);

  logic [BUS_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (data_hit) begin
      for (int l = 0; l < LANES; l++) begin
        rd_next[l*8] = level[{word_idx, LANE_W'(l)}];
      end
    end else if (dir_hit) begin
      rd_next = BUS_W'(dir_words[port_idx]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int PINS_PER_PORT = 32,
  parameter int ADDR_W        = 14,
  parameter int DIR_BASE      = 'h2000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_we,
  input  logic [3:0]                         bus_be,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_oe
);

  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
  localparam int WORDS    = NUM_PINS / LANES;
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  // Address decode, brought out as named events
  logic [31:0]       acc_addr;
  logic [31:0]       port_full;
  logic              data_hit;
  logic              dir_hit;
  logic              data_wr_hit;
  logic              dir_wr_hit;
  logic              unmapped_acc;
  logic [WIDX_W-1:0] word_idx;
  logic [PIDX_W-1:0] port_idx;

  assign acc_addr     = 32'(bus_addr) & ~32'(LANES - 1);
  assign data_hit     = in_data_span(acc_addr, NUM_PINS);
  assign dir_hit      = in_dir_span(acc_addr, DIR_BASE, NUM_PORTS);
  assign data_wr_hit  = bus_we && data_hit;
  assign dir_wr_hit   = bus_we && dir_hit;
  assign unmapped_acc = !data_hit && !dir_hit;
  assign word_idx     = acc_addr[WIDX_W+LANE_W-1:LANE_W];
  assign port_full    = dir_port_of(acc_addr, DIR_BASE);
  assign port_idx     = port_full[PIDX_W-1:0];

  // State
  logic [NUM_PINS-1:0]                     latch_q;
  logic [NUM_PINS-1:0]                     sync_in;
  logic [NUM_PINS-1:0]                     dir_flat;
  logic [NUM_PINS-1:0]                     level;
  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dir_words;

  gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_in)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS), .WIDX_W(WIDX_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (data_wr_hit),
    .word_idx (word_idx),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .latch_q  (latch_q)
  );

  gpio_dir_bank #(
    .NUM_PORTS     (NUM_PORTS),
    .PINS_PER_PORT (PINS_PER_PORT),
    .PIDX_W        (PIDX_W)
  ) u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (dir_wr_hit),
    .port_idx  (port_idx),
    .be        (bus_be),
    .wdata     (bus_wdata),
    .dir_words (dir_words)
  );

  assign dir_flat = dir_words;
  assign level    = (dir_flat & latch_q) | (~dir_flat & sync_in);
  assign pin_oe   = dir_flat;
  assign pin_out  = dir_flat & latch_q;

  gpio_read_port #(
    .NUM_PORTS     (NUM_PORTS),
    .PINS_PER_PORT (PINS_PER_PORT),
    .WIDX_W        (WIDX_W),
    .PIDX_W        (PIDX_W)
  ) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_hit  (data_hit),
    .dir_hit   (dir_hit),
    .word_idx  (word_idx),
    .port_idx  (port_idx),
    .level     (level),
    .dir_words (dir_words),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                data_hit,
  input logic                data_wr_hit,
  input logic                dir_wr_hit,
  input logic                unmapped_acc,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);

  logic prev_data;
  logic prev_unmapped;
  logic prev_dir_wr;
  logic prev_data_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_data     <= 1'b0;
      prev_unmapped <= 1'b0;
      prev_dir_wr   <= 1'b0;
      prev_data_wr  <= 1'b0;
    end else begin
      prev_data     <= data_hit;
      prev_unmapped <= unmapped_acc;
      prev_dir_wr   <= dir_wr_hit;
      prev_data_wr  <= data_wr_hit;
    end
  end

  // R4
  out_gated_by_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R5
  data_byte_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_data |-> ((bus_rdata & 32'hFEFE_FEFE) == 32'h0));

  // R8
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_unmapped |-> (bus_rdata == 32'h0));

  // R3
  oe_moves_only_on_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_dir_wr |-> $stable(pin_oe));

  // R2
  out_moves_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prev_dir_wr || prev_data_wr) |-> $stable(pin_out));

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PORTS*PINS_PER_PORT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .data_hit     (data_hit),
  .data_wr_hit  (data_wr_hit),
  .dir_wr_hit   (dir_wr_hit),
  .unmapped_acc (unmapped_acc),
  .bus_rdata    (bus_rdata),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [13:0]  bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_be = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] pin_in = {8{32'hC3A5_96E1}};
  logic [255:0] pin_out;
  logic [255:0] pin_oe;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t        sb[$];
  int           cyc = 0;
  int           vectors = 0;
  int           fails = 0;
  logic [255:0] m_lat = '0;
  logic [255:0] m_dir = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare registered read data against scoreboard items
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      check(bus_rdata === it.exp, it.req, 256'(bus_rdata), 256'(it.exp));
    end
  end

  function automatic logic [31:0] exp_for(input int a);
    int w;
    logic [31:0] r;
    w = a & ~3;
    r = '0;
    if (w < 256) begin
      for (int l = 0; l < 4; l++) r[8*l] = m_dir[w+l] ? m_lat[w+l] : pin_in[w+l];
    end else if (w >= 'h2000 && w < 'h2020) begin
      r = m_dir[((w - 'h2000) / 4) * 32 +: 32];
    end
    return r;
  endfunction

  task automatic push(input logic [31:0] e, input string req);
    sb.push_back('{cyc + 1, e, req});
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 14'(a); bus_be = '0; bus_wdata = '0;
    push(exp_for(a), req);
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] wd,
                    input bit rd_chk, input string req);
    int w;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 14'(a); bus_be = be; bus_wdata = wd;
    if (rd_chk) push(exp_for(a), req);
    w = a & ~3;
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        if (w < 256) m_lat[w+l] = |wd[8*l +: 8];
        else if (w >= 'h2000 && w < 'h2020) m_dir[((w - 'h2000) / 4) * 32 + 8*l +: 8] = wd[8*l +: 8];
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic check_pins(input string req);
    idle();
    check(pin_oe === m_dir, {req, " oe"}, pin_oe, m_dir);
    check(pin_out === (m_lat & m_dir), {req, " out"}, pin_out, m_lat & m_dir);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] e_old;
    logic [31:0] e_new;
    logic [255:0] snap_oe;
    logic [255:0] snap_out;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(bus_rdata === 32'h0, "R1 rdata in reset", 256'(bus_rdata), 256'h0);
    check(pin_oe === '0 && pin_out === '0, "R1 pins in reset", pin_oe | pin_out, '0);
    rst_n = 1'b1;
    repeat (3) idle();
    check_pins("R1 after reset");
    rd('h2000, "R1 dir port0 zero");
    rd('h201C, "R1 dir port7 zero");
    // R6: input sampling of several words
    rd('h000, "R6 input word 0");
    rd('h0FC, "R6 input word 63");
    rd('h084, "R6 input word 33");
    // R6: synchronizer latency on pin 5
    @(negedge clk);
    e_old = exp_for('h004);
    pin_in[5] = ~pin_in[5];
    e_new = exp_for('h004);
    bus_we = 1'b0; bus_addr = 14'h004;
    push(e_old, "R6 edge+1 old level");
    @(negedge clk); push(e_old, "R6 edge+2 old level");
    @(negedge clk); push(e_new, "R6 edge+3 new level");
    // R2/R7: lane strobes, write while input
    wr('h000, 4'b0101, 32'h00FF_3380, 1'b0, "R2");
    check_pins("R7 latch hidden while input");
    wr('h2000, 4'b1111, 32'h0000_0007, 1'b0, "R3");
    check_pins("R7 stored value driven");
    rd('h000, "R5 output pins read latch");
    rd('h2000, "R3 dir readback port0");
    // R3: byte strobes on direction word
    wr('h201C, 4'b1000, 32'hFFFF_FFFF, 1'b0, "R3");
    rd('h201C, "R3 partial dir write");
    check_pins("R3 port7 top byte");
    // R2: write nonzero then zero to pin 255
    wr('h0FC, 4'b1000, 32'h0100_0000, 1'b0, "R2");
    check_pins("R2 nonzero sets");
    rd('h0FC, "R5 pin 255 reads one");
    wr('h0FC, 4'b1000, 32'h00FF_FFFF, 1'b0, "R2");
    check_pins("R2 zero clears");
    // R4: mixed pattern on port 3
    wr('h206C - 'h60, 4'b1111, 32'hA5A5_0F0F, 1'b0, "R4");
    for (int w = 0; w < 8; w++) begin
      logic [31:0] wd;
      wd = '0;
      for (int l = 0; l < 4; l++) wd[8*l +: 8] = 32'h1234_5678 >> (w*4 + l) & 1 ? 8'h40 : 8'h00;
      wr(96 + 4*w, 4'b1111, wd, 1'b0, "R4");
    end
    check_pins("R4 mixed port3");
    repeat (2) idle();
    rd(104, "R5 mixed port3 read");
    // R8: unmapped accesses
    snap_oe = pin_oe; snap_out = pin_out;
    wr('h100, 4'b1111, 32'hFFFF_FFFF, 1'b0, "R8");
    wr('h2020, 4'b1111, 32'hFFFF_FFFF, 1'b0, "R8");
    wr('h1FFC, 4'b1111, 32'hFFFF_FFFF, 1'b0, "R8");
    idle();
    check(pin_oe === snap_oe, "R8 oe unchanged", pin_oe, snap_oe);
    check(pin_out === snap_out, "R8 out unchanged", pin_out, snap_out);
    rd('h100, "R8 unmapped low read");
    rd('h2020, "R8 unmapped high read");
    rd('h3FFC, "R8 unmapped top read");
    // R9: write and read of the same location in one cycle
    wr('h000, 4'b0001, 32'h0, 1'b1, "R9 data pre-write value");
    rd('h000, "R9 data post-write value");
    wr('h2000, 4'b1111, 32'h0, 1'b1, "R9 dir pre-write value");
    rd('h2000, "R9 dir post-write value");
    rd('h000, "R6 pins back to input");
    check_pins("R9 final pins");
    repeat (3) idle();
    finish_run();
  end

endmodule